// File: doc/BRIEF.md
# Multi-Channel Thermal Sensor Controller

This block is the register front end of a temperature monitor that watches several on-die sensor channels. Software sets a sampling pace, picks which channels take part, and sets two danger levels. A small timer then visits the enabled channels one at a time. Each visit takes the channel's raw reading from an input port, can smooth it against the previous value, and stores it. The visit then raises status flags that software can read.

Readings fall as the die gets hotter. A channel whose stored value goes below the warning level raises its alarm flag. A value below the critical level raises its shutdown flag. Every completed visit raises the channel's data-ready flag. Software acknowledges flags by writing ones to them. A single interrupt line is high while any acknowledged-able flag is pending and enabled.

All registers are 32 bits wide and are reached through a simple one-cycle write strobe with a combinational read port. Two calibration words and a calibration-enable bit are held for software and have no effect on the datapath.

Top module: `thermal_sense_ctrl`

## Requirements
- R1: After reset every register reads zero, the interrupt output is low, and no channel is sampled.
- R2: With count N in bits 15:0 of offset 0x00 and a set of channels enabled, one sample is taken every N+1 cycles. The first sample falls N+1 cycles after the enable write takes effect.
- R3: Enabled channels (bits 2:0 of offset 0x40, bit n for channel n) are visited in rising cyclic order starting at channel 0. Disabled channels are skipped, and their data registers keep their value.
- R4: The stored 12-bit reading of channel n reads at offset 0x80+4n in bits 11:0. With the filter off, it equals the raw input sampled at the visit.
- R5: With bit 2 of offset 0x70 set, a visit stores floor((previous stored value + raw input)/2) instead of the raw input.
- R6: Each visit to channel n sets status bit 8+n. It also sets bit n when the stored value is below the warning level (bits 11:0 of 0x50), and bit 4+n when the stored value is below the critical level (bits 11:0 of 0x54). Status is at offset 0x48.
- R7: Writing a one to a status bit clears it, and writing a zero leaves it. A flag raised in the same cycle as its clearing write stays set.
- R8: The interrupt output is high exactly when some status bit is set and the bit at the same position of offset 0x44 is also set.
- R9: Configuration reads back masked. Offset 0x04 keeps only bit 17. Offset 0x40 keeps bits 31:16 and the channel enables. Offset 0x70 keeps only bit 2. Offsets 0x74 and 0x78 keep all 32 bits.
- R10: With no channel enabled the timer holds at zero, no sample is taken, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sens_raw | input | NCH*DW | Raw readings, channel n in bits n*DW +: DW |
| irq | output | 1 | Combined interrupt, level |

## Verification
The checker assumes that software writes the status register only through the write strobe. It also assumes the acquire count is not lowered to zero in the cycle where the timer fires, and that reset is held over at least one clock edge. The stimulus follows these rules: it issues every write as a single strobe at the falling edge, and it rewrites the count only while every channel is disabled. The raw sensor inputs change only at falling edges, so each visit samples a stable value. This keeps the predicted sample cycles exact.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   // register offsets (bytes)
   localparam int OFS_CTL0 = 'h00;
   localparam int OFS_CTL1 = 'h04;
   localparam int OFS_CTL2 = 'h40;
   localparam int OFS_IEN  = 'h44;
   localparam int OFS_STS  = 'h48;
   localparam int OFS_ATHR = 'h50;
   localparam int OFS_STHR = 'h54;
   localparam int OFS_FILT = 'h70;
   localparam int OFS_CAL0 = 'h74;
   localparam int OFS_CAL1 = 'h78;
   localparam int OFS_DATA = 'h80;

   // status field layout
   localparam int ALM_BASE   = 0;
   localparam int SHUT_BASE  = 4;
   localparam int RDY_BASE   = 8;
   localparam int FLD_STRIDE = 4;

   localparam int CAL_EN_BIT  = 17;
   localparam int FILT_EN_BIT = 2;
   localparam int ACQ2_LSB    = 16;

   typedef struct packed {
      logic rdy;
      logic alm;
      logic sht;
   } chan_flags_t;
endpackage

// File: rtl/tsc_acq_timer.sv
module tsc_acq_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             tick
);
   logic [CNT_W-1:0] cnt_q;

   assign tick = run && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else if (tick)  cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/tsc_rr_pick.sv
module tsc_rr_pick #(
   parameter int NCH = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic [NCH-1:0] en,
   output logic [NCH-1:0] grant
);
   localparam int PW = (NCH > 1) ? $clog2(NCH) : 1;
   localparam logic [PW-1:0] LAST = PW'(NCH - 1);

   logic [PW-1:0] ptr_q, nxt;
   logic          found;

   always_comb begin
      grant = '0;
      found = 1'b0;
      nxt   = ptr_q;
      for (int k = 1; k <= NCH; k++) begin
         int idx;
         idx = (int'(ptr_q) + k) % NCH;
         if (!found && en[idx]) begin
            found      = 1'b1;
            nxt        = PW'(idx);
            grant[idx] = tick;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ptr_q <= LAST;
      else if (tick && found)  ptr_q <= nxt;
   end
endmodule

// File: rtl/tsc_chan_slot.sv
module tsc_chan_slot import tsc_pkg::*; #(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          filt_en,
   input  logic [DW-1:0] raw,
   input  logic [DW-1:0] athr,
   input  logic [DW-1:0] sthr,
   output logic [DW-1:0] data,
   output chan_flags_t   flags
);
   logic [DW-1:0] data_q, nxt;
   logic [DW:0]   sum;

   assign sum = {1'b0, data_q} + {1'b0, raw};
   assign nxt = filt_en ? sum[DW:1] : raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    data_q <= '0;
      else if (take) data_q <= nxt;
   end

   assign data      = data_q;
   assign flags.rdy = take;
   assign flags.alm = take && (nxt < athr);
   assign flags.sht = take && (nxt < sthr);
endmodule

// File: rtl/thermal_sense_ctrl.sv
module thermal_sense_ctrl import tsc_pkg::*; #(
   parameter int NCH   = 3,
   parameter int DW    = 12,
   parameter int AW    = 8,
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NCH*DW-1:0] sens_raw,
   output logic              irq
);
   localparam int STS_W = RDY_BASE + FLD_STRIDE;

   function automatic logic [STS_W-1:0] sts_mask_f();
      logic [STS_W-1:0] m;
      m = '0;
      for (int i = 0; i < NCH; i++) begin
         m[ALM_BASE + i]  = 1'b1;
         m[SHUT_BASE + i] = 1'b1;
         m[RDY_BASE + i]  = 1'b1;
      end
      return m;
   endfunction

   localparam logic [STS_W-1:0] STS_MASK = sts_mask_f();

   generate
      if (NCH < 1 || NCH > FLD_STRIDE) begin : g_bad_nch
         $error("NCH must lie in 1..%0d", FLD_STRIDE);
      end
      if (DW < 2 || DW > 16) begin : g_bad_dw
         $error("DW must lie in 2..16");
      end
      if (AW < 8) begin : g_bad_aw
         $error("AW must be at least 8");
      end
      if (CNT_W < 1 || CNT_W > ACQ2_LSB) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
   endgenerate

   // configuration and status state
   logic [CNT_W-1:0]  acq_lim;
   logic              cal_en;
   logic [15:0]       acq2;
   logic [NCH-1:0]    chan_en;
   logic [STS_W-1:0]  ien_q, sts_q, set_vec;
   logic              filt_en;
   logic [31:0]       cal0_q, cal1_q;
   logic [DW-1:0]     athr_q, sthr_q;
   logic              sts_wr;
   logic              acq_tick;
   logic [NCH-1:0]    grant, rdy_set;
   logic [NCH*DW-1:0] data_flat;
   chan_flags_t       flags [NCH];

   assign sts_wr = bus_wr && (bus_addr == AW'(OFS_STS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acq_lim <= '0;
         cal_en  <= 1'b0;
         acq2    <= '0;
         chan_en <= '0;
         ien_q   <= '0;
         filt_en <= 1'b0;
         cal0_q  <= '0;
         cal1_q  <= '0;
         athr_q  <= '0;
         sthr_q  <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            AW'(OFS_CTL0): acq_lim <= bus_wdata[CNT_W-1:0];
            AW'(OFS_CTL1): cal_en  <= bus_wdata[CAL_EN_BIT];
            AW'(OFS_CTL2): begin
               acq2    <= bus_wdata[31:ACQ2_LSB];
               chan_en <= bus_wdata[NCH-1:0];
            end
            AW'(OFS_IEN):  ien_q   <= bus_wdata[STS_W-1:0] & STS_MASK;
            AW'(OFS_FILT): filt_en <= bus_wdata[FILT_EN_BIT];
            AW'(OFS_CAL0): cal0_q  <= bus_wdata;
            AW'(OFS_CAL1): cal1_q  <= bus_wdata;
            AW'(OFS_ATHR): athr_q  <= bus_wdata[DW-1:0];
            AW'(OFS_STHR): sthr_q  <= bus_wdata[DW-1:0];
            default: ;
         endcase
      end
   end

   // status: write-one-to-clear, new flags take priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~(sts_wr ? bus_wdata[STS_W-1:0] : '0)) | set_vec;
   end

   tsc_acq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (|chan_en),
      .limit (acq_lim),
      .tick  (acq_tick)
   );

   tsc_rr_pick #(.NCH(NCH)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (acq_tick),
      .en    (chan_en),
      .grant (grant)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_chan
         tsc_chan_slot #(.DW(DW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (grant[i]),
            .filt_en (filt_en),
            .raw     (sens_raw[i*DW +: DW]),
            .athr    (athr_q),
            .sthr    (sthr_q),
            .data    (data_flat[i*DW +: DW]),
            .flags   (flags[i])
         );
         assign rdy_set[i] = flags[i].rdy;
      end
   endgenerate

   always_comb begin
      set_vec = '0;
      for (int i = 0; i < NCH; i++) begin
         set_vec[ALM_BASE + i]  = flags[i].alm;
         set_vec[SHUT_BASE + i] = flags[i].sht;
         set_vec[RDY_BASE + i]  = flags[i].rdy;
      end
   end

   // read port
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         AW'(OFS_CTL0): bus_rdata = 32'(acq_lim);
         AW'(OFS_CTL1): bus_rdata[CAL_EN_BIT] = cal_en;
         AW'(OFS_CTL2): begin
            bus_rdata[31:ACQ2_LSB] = acq2;
            bus_rdata[NCH-1:0]     = chan_en;
         end
         AW'(OFS_IEN):  bus_rdata = 32'(ien_q);
         AW'(OFS_STS):  bus_rdata = 32'(sts_q);
         AW'(OFS_FILT): bus_rdata[FILT_EN_BIT] = filt_en;
         AW'(OFS_CAL0): bus_rdata = cal0_q;
         AW'(OFS_CAL1): bus_rdata = cal1_q;
         AW'(OFS_ATHR): bus_rdata = 32'(athr_q);
         AW'(OFS_STHR): bus_rdata = 32'(sthr_q);
         default: begin
            for (int i = 0; i < NCH; i++)
               if (bus_addr == AW'(OFS_DATA + 4*i))
                  bus_rdata = 32'(data_flat[i*DW +: DW]);
         end
      endcase
   end

   assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
   parameter int NCH   = 3,
   parameter int DW    = 12,
   parameter int STS_W = 12,
   parameter int CNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic [STS_W-1:0]  sts,
   input logic [STS_W-1:0]  ien,
   input logic              sts_wr,
   input logic              tick,
   input logic [CNT_W-1:0]  lim,
   input logic [NCH-1:0]    chan_en,
   input logic [NCH-1:0]    rdy_set,
   input logic [NCH*DW-1:0] data_flat
);
   AST_ONE_VISIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rdy_set)); // R3

   AST_SKIP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_set & ~chan_en) == '0); // R3

   AST_VISIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_set != '0) |-> tick); // R2

   AST_PERIOD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (!tick || lim == '0)); // R2

   AST_NO_RUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en == '0) |-> (rdy_set == '0)); // R10

   AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sts_wr) |-> (($past(sts) & ~sts) == '0)); // R7

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (sts != $past(sts) || ien != $past(ien))); // R8

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_hold
         AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rdy_set[i]) |-> $stable(data_flat[i*DW +: DW])); // R3
      end
   endgenerate
endmodule

bind thermal_sense_ctrl tsc_checker #(
   .NCH   (NCH),
   .DW    (DW),
   .STS_W (STS_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .sts       (sts_q),
   .ien       (ien_q),
   .sts_wr    (sts_wr),
   .tick      (acq_tick),
   .lim       (acq_lim),
   .chan_en   (chan_en),
   .rdy_set   (rdy_set),
   .data_flat (data_flat)
);

// File: tb/tb_thermal_sense_ctrl.sv
module tb_thermal_sense_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [35:0] sens;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   thermal_sense_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sens_raw(sens), .irq(irq)
   );

   // behavioural reference model
   int unsigned m_ctl0, m_ctl1, m_ctl2, m_ien, m_fil, m_cal0, m_cal1;
   int unsigned m_tha, m_ths, m_sts, m_cnt;
   int unsigned m_dat[3];
   int          m_ptr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctl0 = 0; m_ctl1 = 0; m_ctl2 = 0; m_ien = 0; m_fil = 0;
         m_cal0 = 0; m_cal1 = 0; m_tha = 0; m_ths = 0; m_sts = 0; m_cnt = 0;
         foreach (m_dat[i]) m_dat[i] = 0;
         m_ptr = 2;
      end else begin
         int unsigned en, setb, v, s;
         bit tk;
         int ch;
         en   = m_ctl2 & 7;
         tk   = (en != 0) && (m_cnt >= (m_ctl0 & 'hffff));
         setb = 0;
         if (en == 0 || tk) m_cnt = 0; else m_cnt++;
         if (tk) begin
            ch = -1;
            for (int k = 1; k <= 3; k++)
               if (ch < 0 && en[(m_ptr + k) % 3]) ch = (m_ptr + k) % 3;
            m_ptr = ch;
            s = 32'((sens >> (12 * ch)) & 36'hfff);
            v = (m_fil & 4) != 0 ? (m_dat[ch] + s) >> 1 : s;
            m_dat[ch] = v;
            setb = 32'h100 << ch;
            if (v < m_tha) setb |= 32'h1 << ch;
            if (v < m_ths) setb |= 32'h10 << ch;
         end
         if (bus_wr) begin
            case (bus_addr)
               8'h00: m_ctl0 = bus_wdata & 'hffff;
               8'h04: m_ctl1 = bus_wdata & 'h20000;
               8'h40: m_ctl2 = bus_wdata & 'hffff0007;
               8'h44: m_ien  = bus_wdata & 'h777;
               8'h48: m_sts  = m_sts & ~(bus_wdata & 'h777);
               8'h50: m_tha  = bus_wdata & 'hfff;
               8'h54: m_ths  = bus_wdata & 'hfff;
               8'h70: m_fil  = bus_wdata & 4;
               8'h74: m_cal0 = bus_wdata;
               8'h78: m_cal1 = bus_wdata;
               default: ;
            endcase
         end
         m_sts |= setb;
      end
   end

   function automatic int unsigned m_read(input logic [7:0] a);
      case (a)
         8'h00: return m_ctl0;
         8'h04: return m_ctl1;
         8'h40: return m_ctl2;
         8'h44: return m_ien;
         8'h48: return m_sts;
         8'h50: return m_tha;
         8'h54: return m_ths;
         8'h70: return m_fil;
         8'h74: return m_cal0;
         8'h78: return m_cal1;
         8'h80: return m_dat[0];
         8'h84: return m_dat[1];
         8'h88: return m_dat[2];
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string req, input int unsigned act, input int unsigned exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // interrupt compared with the model on every cycle (R8)
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done)
         chk("R8 irq per cycle", 32'(irq), 32'((m_sts & m_ien) != 0));
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input int unsigned exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
      chk({req, " model"}, bus_rdata, m_read(a));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int n;
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; sens = '0;
      idle(3);
      rst_n = 1'b1;
      // R1: reset state
      foreach (dut.sts_q[i]) ; // no-op placeholder-free loop avoided below
      rd("R1 ctl0", 8'h00, 0);
      rd("R1 ctl2", 8'h40, 0);
      rd("R1 sts",  8'h48, 0);
      rd("R1 cal0", 8'h74, 0);
      rd("R1 data0", 8'h80, 0);
      rd("R1 data2", 8'h88, 0);
      chk("R1 irq", 32'(irq), 0);
      idle(5);
      rd("R1 no sample", 8'h48, 0);

      // R9: masked configuration readback
      wr(8'h04, 32'hffffffff);
      wr(8'h40, 32'habcdfff8);
      wr(8'h00, 32'h00012345);
      wr(8'h70, 32'hfffffffb);
      wr(8'h74, 32'hdeadbeef);
      wr(8'h78, 32'h0badf00d);
      rd("R9 ctl1", 8'h04, 32'h00020000);
      rd("R9 ctl2", 8'h40, 32'habcd0000);
      rd("R9 ctl0", 8'h00, 32'h00002345);
      rd("R9 filter", 8'h70, 0);
      rd("R9 cal0", 8'h74, 32'hdeadbeef);
      rd("R9 cal1", 8'h78, 32'h0badf00d);

      // R6/R4/R3: two channels running, warning 0x400, critical 0x100
      wr(8'h50, 32'h400);
      wr(8'h54, 32'h100);
      sens = {12'h050, 12'h300, 12'h800};
      wr(8'h00, 32'd3);
      wr(8'h40, 32'habcd0005);
      idle(30);
      rd("R4 data0", 8'h80, 32'h800);
      rd("R3 data1 skipped", 8'h84, 0);
      rd("R4 data2", 8'h88, 32'h050);
      rd("R6 flags", 8'h48, 32'h544);

      // R7: writing zero leaves status
      wr(8'h48, 32'h0);
      rd("R7 zero write", 8'h48, 32'h544);
      // R8: masked interrupt
      wr(8'h44, 32'h040);
      chk("R8 shut enabled", 32'(irq), 1);
      wr(8'h44, 32'h001);
      chk("R8 alarm0 absent", 32'(irq), 0);

      // R2: gap between channel 0 visits = 2 channels * (3+1)
      wr(8'h48, 32'h777);
      wr(8'h44, 32'h100);
      while (!irq) @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h100;
      @(negedge clk);
      bus_wr = 1'b0;
      n = 1;
      while (!irq && n < 100) begin @(negedge clk); n++; end
      chk("R2 visit spacing", n, 8);

      // R7: set wins over clear when sampling every cycle
      wr(8'h40, 32'h0);
      wr(8'h00, 32'h0);
      wr(8'h40, 32'h1);
      idle(3);
      wr(8'h48, 32'h100);
      bus_addr = 8'h48; #1;
      chk("R7 set beats clear", bus_rdata & 32'h100, 32'h100);

      // R5: filter averages with the previous value (channel 1 held 0)
      wr(8'h40, 32'h0);
      wr(8'h70, 32'h4);
      wr(8'h40, 32'h2);
      wr(8'h40, 32'h0);
      rd("R5 filtered", 8'h84, 32'h180);

      // R10: nothing enabled, inputs change, nothing moves
      wr(8'h48, 32'h777);
      sens = {12'h001, 12'h002, 12'h003};
      idle(20);
      rd("R10 no flags", 8'h48, 0);
      rd("R10 data0 held", 8'h80, 32'h800);
      rd("R10 data2 held", 8'h88, 32'h050);

      // R3: round robin over all three, filter off
      wr(8'h70, 32'h0);
      wr(8'h00, 32'h1);
      wr(8'h40, 32'h7);
      idle(12);
      wr(8'h40, 32'h0);
      rd("R3 data0", 8'h80, 32'h003);
      rd("R3 data1", 8'h84, 32'h002);
      rd("R3 data2", 8'h88, 32'h001);
      rd("R6 all shut", 8'h48, 32'h777);

      // R1: reset again clears everything
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      rd("R1 sts after reset", 8'h48, 0);
      rd("R1 data1 after reset", 8'h84, 0);
      idle(2);
      finish_run();
   end
endmodule